// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder/Subtractor Pipeline

This block adds or subtracts two floating-point operands held in sign-magnitude form. Each operand is a sign bit, an unsigned exponent and a fraction mantissa whose top bit is set when the operand is normalized. The work is split into four register-separated segments. The first compares the exponents. The second aligns the mantissa of the operand with the smaller exponent. The third adds or subtracts the magnitudes. The fourth normalizes the result in either direction and corrects the exponent.

A new operation can enter on every clock. Its result leaves a fixed four clocks later with a valid flag. Overflow and underflow of the exponent are reported by flags. The exponent itself wraps and is not saturated. Rounding, infinities, NaNs and denormals are not handled. Bits shifted out during alignment are dropped.

Top module: `fpa_pipe_top`

## Requirements
- R1: An operand is {sign, exponent (EW=8 bits, unsigned), mantissa (MW=24 bits, a fraction; bit 23 set when normalized, or all zero for a zero value)}. `op_sub`=0 selects a+b. `op_sub`=1 selects a-b, which is done by inverting the sign of b.
- R2: One operation is accepted per clock. `out_valid` and the result of an operation sampled with `in_valid`=1 at a rising edge appear after the fourth rising edge counted from that one.
- R3: The result exponent before normalization is the larger input exponent. On a tie, a is taken as the larger-exponent operand. The other mantissa is shifted right by the exponent difference, and bits shifted out are discarded.
- R4: An alignment shift of 24 or more places gives an aligned mantissa of zero.
- R5: When the effective signs agree, the magnitudes are added and the result takes their common sign. Otherwise the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger magnitude.
- R6: A carry out of the mantissa sum shifts the mantissa right one place and increments the exponent.
- R7: A nonzero result with leading zeros is shifted left until bit 23 is 1. The exponent is decremented once for each position shifted.
- R8: A zero mantissa result gives sign 0, exponent 0 and mantissa 0, and raises `out_zero`.
- R9: A carry with an exponent of 255 raises `out_ovf`, and the exponent wraps to 0.
- R10: A left shift larger than the exponent raises `out_unf`, and the exponent wraps modulo 256. At most one of the three flags is set at a time.
- R11: An active-low `rst_n` clears `out_valid` and every result output to zero at once, with no clock needed.
- R12: A cycle with `in_valid`=0 gives `out_valid`=0 in its output slot. The result outputs keep their previous values during that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| op_sub | input | 1 | 0 add, 1 subtract |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | 8 | Exponent of operand a |
| a_mant | input | 24 | Mantissa of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | 8 | Exponent of operand b |
| b_mant | input | 24 | Mantissa of operand b |
| out_valid | output | 1 | Result present on the outputs |
| out_sign | output | 1 | Result sign |
| out_exp | output | 8 | Result exponent |
| out_mant | output | 24 | Result mantissa |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow |
| out_zero | output | 1 | Result is zero |

## Verification
The assertions assume that every operand presented with `in_valid` high is either normalized or an exact zero, with a zero mantissa. The output properties depend on this. These properties are the set top bit, the clean zero encoding and the exclusive flags. The stimulus uses only normalized mantissas, plus one all-zero operand. Unnormalized inputs are never applied, so the normalization stage is always exercised from well-formed sums. The assertions also treat the valid chain as starting at the internally synchronized reset release. For that reason the bench holds `in_valid` low for several clocks after releasing `rst_n`.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned FPA_MW = 24;
  localparam int unsigned FPA_EW = 8;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpa_op_e;
endpackage

// File: rtl/fpa_rst_sync.sv
module fpa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpa_exp_compare.sv
module fpa_exp_compare #(
  parameter int unsigned MW = 24,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_mant,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_mant,
  output logic          s1_valid,
  output logic          s1_big_sign,
  output logic [MW-1:0] s1_big_mant,
  output logic          s1_sml_sign,
  output logic [MW-1:0] s1_sml_mant,
  output logic [EW-1:0] s1_exp,
  output logic [EW-1:0] s1_shift
);
  logic          b_eff_sign;
  logic          a_wins;
  logic          big_sign_d, sml_sign_d;
  logic [MW-1:0] big_mant_d, sml_mant_d;
  logic [EW-1:0] exp_d, shift_d;

  always_comb begin
    b_eff_sign = b_sign ^ (op_sub == fpa_pkg::OP_SUB);
    a_wins     = (a_exp >= b_exp);
    if (a_wins) begin
      big_sign_d = a_sign;     big_mant_d = a_mant;
      sml_sign_d = b_eff_sign; sml_mant_d = b_mant;
      exp_d      = a_exp;      shift_d    = a_exp - b_exp;
    end else begin
      big_sign_d = b_eff_sign; big_mant_d = b_mant;
      sml_sign_d = a_sign;     sml_mant_d = a_mant;
      exp_d      = b_exp;      shift_d    = b_exp - a_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_big_sign <= 1'b0; s1_big_mant <= '0;
      s1_sml_sign <= 1'b0; s1_sml_mant <= '0;
      s1_exp      <= '0;   s1_shift    <= '0;
    end else if (in_valid) begin
      s1_big_sign <= big_sign_d; s1_big_mant <= big_mant_d;
      s1_sml_sign <= sml_sign_d; s1_sml_mant <= sml_mant_d;
      s1_exp      <= exp_d;      s1_shift    <= shift_d;
    end
  end
endmodule

// File: rtl/fpa_mant_align.sv
module fpa_mant_align #(
  parameter int unsigned MW = 24,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  logic          s1_big_sign,
  input  logic [MW-1:0] s1_big_mant,
  input  logic          s1_sml_sign,
  input  logic [MW-1:0] s1_sml_mant,
  input  logic [EW-1:0] s1_exp,
  input  logic [EW-1:0] s1_shift,
  output logic          s2_valid,
  output logic          s2_big_sign,
  output logic [MW-1:0] s2_big_mant,
  output logic          s2_sml_sign,
  output logic [MW-1:0] s2_aligned,
  output logic [EW-1:0] s2_exp
);
  logic [MW-1:0] aligned_d;
  logic          too_far;

  always_comb begin
    too_far   = (32'(s1_shift) >= 32'(MW));
    aligned_d = too_far ? '0 : (s1_sml_mant >> s1_shift);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_big_sign <= 1'b0; s2_big_mant <= '0;
      s2_sml_sign <= 1'b0; s2_aligned  <= '0;
      s2_exp      <= '0;
    end else if (s1_valid) begin
      s2_big_sign <= s1_big_sign; s2_big_mant <= s1_big_mant;
      s2_sml_sign <= s1_sml_sign; s2_aligned  <= aligned_d;
      s2_exp      <= s1_exp;
    end
  end
endmodule

// File: rtl/fpa_mant_addsub.sv
module fpa_mant_addsub #(
  parameter int unsigned MW = 24,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s2_valid,
  input  logic          s2_big_sign,
  input  logic [MW-1:0] s2_big_mant,
  input  logic          s2_sml_sign,
  input  logic [MW-1:0] s2_aligned,
  input  logic [EW-1:0] s2_exp,
  output logic          s3_valid,
  output logic          s3_sign,
  output logic [MW:0]   s3_sum,
  output logic [EW-1:0] s3_exp
);
  logic          eff_sub;
  logic          big_ge;
  logic [MW:0]   sum_d;
  logic          sign_d;

  always_comb begin
    eff_sub = s2_big_sign ^ s2_sml_sign;
    big_ge  = (s2_big_mant >= s2_aligned);
    if (!eff_sub) begin
      sum_d  = {1'b0, s2_big_mant} + {1'b0, s2_aligned};
      sign_d = s2_big_sign;
    end else if (big_ge) begin
      sum_d  = {1'b0, s2_big_mant} - {1'b0, s2_aligned};
      sign_d = s2_big_sign;
    end else begin
      sum_d  = {1'b0, s2_aligned} - {1'b0, s2_big_mant};
      sign_d = s2_sml_sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_valid <= 1'b0;
    else        s3_valid <= s2_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_sign <= 1'b0; s3_sum <= '0; s3_exp <= '0;
    end else if (s2_valid) begin
      s3_sign <= sign_d; s3_sum <= sum_d; s3_exp <= s2_exp;
    end
  end
endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize #(
  parameter int unsigned MW = 24,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s3_valid,
  input  logic          s3_sign,
  input  logic [MW:0]   s3_sum,
  input  logic [EW-1:0] s3_exp,
  output logic          out_valid,
  output logic          out_sign,
  output logic [EW-1:0] out_exp,
  output logic [MW-1:0] out_mant,
  output logic          out_ovf,
  output logic          out_unf,
  output logic          out_zero
);
  localparam int unsigned LZW = $clog2(MW + 1);

  logic [LZW-1:0] lead_zeros;
  logic           sign_d, ovf_d, unf_d, zero_d;
  logic [EW-1:0]  exp_d;
  logic [MW-1:0]  mant_d;

  always_comb begin
    lead_zeros = '0;
    for (int i = 0; i < int'(MW); i++) begin
      if (s3_sum[i]) lead_zeros = LZW'(int'(MW) - 1 - i);
    end
  end

  always_comb begin
    sign_d = s3_sign;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    zero_d = 1'b0;
    if (s3_sum[MW]) begin
      mant_d = s3_sum[MW:1];
      exp_d  = s3_exp + 1'b1;
      ovf_d  = (s3_exp == '1);
    end else if (s3_sum == '0) begin
      mant_d = '0;
      exp_d  = '0;
      sign_d = 1'b0;
      zero_d = 1'b1;
    end else begin
      mant_d = s3_sum[MW-1:0] << lead_zeros;
      exp_d  = s3_exp - EW'(lead_zeros);
      unf_d  = (32'(lead_zeros) > 32'(s3_exp));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s3_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sign <= 1'b0; out_exp <= '0; out_mant <= '0;
      out_ovf  <= 1'b0; out_unf <= 1'b0; out_zero <= 1'b0;
    end else if (s3_valid) begin
      out_sign <= sign_d; out_exp <= exp_d; out_mant <= mant_d;
      out_ovf  <= ovf_d;  out_unf <= unf_d; out_zero <= zero_d;
    end
  end
endmodule

// File: rtl/fpa_pipe_top.sv
module fpa_pipe_top #(
  parameter int unsigned MW = fpa_pkg::FPA_MW,
  parameter int unsigned EW = fpa_pkg::FPA_EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_mant,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_mant,
  output logic          out_valid,
  output logic          out_sign,
  output logic [EW-1:0] out_exp,
  output logic [MW-1:0] out_mant,
  output logic          out_ovf,
  output logic          out_unf,
  output logic          out_zero
);
  logic          rst_sync_n;
  logic          s1_valid, s1_big_sign, s1_sml_sign;
  logic [MW-1:0] s1_big_mant, s1_sml_mant;
  logic [EW-1:0] s1_exp, s1_shift;
  logic          s2_valid, s2_big_sign, s2_sml_sign;
  logic [MW-1:0] s2_big_mant, s2_aligned;
  logic [EW-1:0] s2_exp;
  logic          s3_valid, s3_sign;
  logic [MW:0]   s3_sum;
  logic [EW-1:0] s3_exp;

  fpa_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fpa_exp_compare #(.MW(MW), .EW(EW)) u_stage1 (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .op_sub(op_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .s1_valid(s1_valid), .s1_big_sign(s1_big_sign), .s1_big_mant(s1_big_mant),
    .s1_sml_sign(s1_sml_sign), .s1_sml_mant(s1_sml_mant),
    .s1_exp(s1_exp), .s1_shift(s1_shift)
  );

  fpa_mant_align #(.MW(MW), .EW(EW)) u_stage2 (
    .clk(clk), .rst_n(rst_sync_n), .s1_valid(s1_valid),
    .s1_big_sign(s1_big_sign), .s1_big_mant(s1_big_mant),
    .s1_sml_sign(s1_sml_sign), .s1_sml_mant(s1_sml_mant),
    .s1_exp(s1_exp), .s1_shift(s1_shift),
    .s2_valid(s2_valid), .s2_big_sign(s2_big_sign), .s2_big_mant(s2_big_mant),
    .s2_sml_sign(s2_sml_sign), .s2_aligned(s2_aligned), .s2_exp(s2_exp)
  );

  fpa_mant_addsub #(.MW(MW), .EW(EW)) u_stage3 (
    .clk(clk), .rst_n(rst_sync_n), .s2_valid(s2_valid),
    .s2_big_sign(s2_big_sign), .s2_big_mant(s2_big_mant),
    .s2_sml_sign(s2_sml_sign), .s2_aligned(s2_aligned), .s2_exp(s2_exp),
    .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_sum(s3_sum), .s3_exp(s3_exp)
  );

  fpa_normalize #(.MW(MW), .EW(EW)) u_stage4 (
    .clk(clk), .rst_n(rst_sync_n), .s3_valid(s3_valid), .s3_sign(s3_sign),
    .s3_sum(s3_sum), .s3_exp(s3_exp),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_ovf(out_ovf), .out_unf(out_unf),
    .out_zero(out_zero)
  );
endmodule

// File: rtl/fpa_pipe_chk.sv
module fpa_pipe_chk #(
  parameter int unsigned MW = 24,
  parameter int unsigned EW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_sign,
  input logic [EW-1:0] out_exp,
  input logic [MW-1:0] out_mant,
  input logic          out_ovf,
  input logic          out_unf,
  input logic          out_zero
);
  logic [3:0] vld_hist;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_hist <= '0;
    else             vld_hist <= {vld_hist[2:0], in_valid};
  end

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == vld_hist[3]);

  a_r7_msb_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_zero) |-> out_mant[MW-1]);

  a_r8_zero_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_zero |-> (out_exp == '0 && out_mant == '0 && !out_sign));

  a_r9_ovf_wraps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_ovf |-> (out_exp == '0));

  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({out_ovf, out_unf, out_zero}));

  a_r12_hold_on_bubble: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> ($stable(out_mant) && $stable(out_exp) && $stable(out_sign)));
endmodule

bind fpa_pipe_top fpa_pipe_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
  .out_mant(out_mant), .out_ovf(out_ovf), .out_unf(out_unf),
  .out_zero(out_zero)
);

// File: tb/fpa_pipe_top_tb.sv
module fpa_pipe_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int VW = 103;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0;
  logic        a_sign = 1'b0, b_sign = 1'b0;
  logic [7:0]  a_exp = '0, b_exp = '0;
  logic [23:0] a_mant = '0, b_mant = '0;
  logic        out_valid, out_sign, out_ovf, out_unf, out_zero;
  logic [7:0]  out_exp;
  logic [23:0] out_mant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpa_pipe_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_ovf(out_ovf), .out_unf(out_unf),
    .out_zero(out_zero)
  );

  // {op, a_s, a_e, a_m, b_s, b_e, b_m, exp_s, exp_e, exp_m, ovf, unf, zero}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    // R6: equal exponents, carry out
    {1'b0, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd11, 24'h800000, 3'b000},
    // R3: b one exponent smaller, aligned and added
    {1'b0, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd9,  24'h800000, 1'b0, 8'd10, 24'hC00000, 3'b000},
    // R8: a-a gives clean zero
    {1'b1, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd0,  24'h000000, 3'b001},
    // R7: subtraction leaves one leading zero
    {1'b1, 1'b0, 8'd10, 24'hC00000, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd9,  24'h800000, 3'b000},
    // R5: subtrahend larger, result takes its sign
    {1'b1, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd10, 24'hC00000, 1'b1, 8'd9,  24'h800000, 3'b000},
    // R5: add with negative larger b, two leading zeros (R7)
    {1'b0, 1'b0, 8'd5,  24'h800000, 1'b1, 8'd5,  24'hA00000, 1'b1, 8'd3,  24'h800000, 3'b000},
    // R4: shift of 30 gives zero aligned mantissa
    {1'b0, 1'b0, 8'd40, 24'h800000, 1'b0, 8'd10, 24'hFFFFFF, 1'b0, 8'd40, 24'h800000, 3'b000},
    // R3: shift of 23 keeps one bit
    {1'b0, 1'b0, 8'd33, 24'h800000, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd33, 24'h800001, 3'b000},
    // R4: shift of exactly 24 gives zero
    {1'b0, 1'b0, 8'd34, 24'h800000, 1'b0, 8'd10, 24'h800000, 1'b0, 8'd34, 24'h800000, 3'b000},
    // R1: b has larger exponent, subtract flips its sign
    {1'b1, 1'b0, 8'd9,  24'h800000, 1'b0, 8'd10, 24'h800000, 1'b1, 8'd9,  24'h800000, 3'b000},
    // R9: carry at exponent 255 wraps to 0
    {1'b0, 1'b0, 8'd255,24'h800000, 1'b0, 8'd255,24'h800000, 1'b0, 8'd0,  24'h800000, 3'b100},
    // R10: 23 leading zeros at exponent 1, wraps to 234
    {1'b1, 1'b0, 8'd1,  24'h800000, 1'b0, 8'd1,  24'h800001, 1'b1, 8'd234,24'h800000, 3'b010},
    // R3: bit shifted out is discarded
    {1'b0, 1'b0, 8'd2,  24'h800000, 1'b0, 8'd1,  24'h800001, 1'b0, 8'd2,  24'hC00000, 3'b000},
    // R5: both negative, sum keeps sign (R6)
    {1'b0, 1'b1, 8'd4,  24'h800000, 1'b1, 8'd4,  24'h800000, 1'b1, 8'd5,  24'h800000, 3'b000},
    // R6: all-ones mantissas, carry and shift
    {1'b0, 1'b0, 8'd3,  24'hFFFFFF, 1'b0, 8'd3,  24'hFFFFFF, 1'b0, 8'd4,  24'hFFFFFF, 3'b000},
    // R1: zero operand a with smaller exponent
    {1'b0, 1'b0, 8'd0,  24'h000000, 1'b0, 8'd7,  24'h900000, 1'b0, 8'd7,  24'h900000, 3'b000}
  };
  localparam int VREQ [NVEC] = '{6, 3, 8, 7, 5, 5, 4, 3, 4, 1, 9, 10, 3, 5, 6, 1};

  function automatic logic [35:0] got_word();
    return {out_sign, out_exp, out_mant, out_ovf, out_unf, out_zero};
  endfunction

  task automatic drive(input logic [VW-1:0] v, input logic vld);
    in_valid = vld;
    {op_sub, a_sign, a_exp, a_mant, b_sign, b_exp, b_mant} = v[VW-1:36];
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: outputs during reset
    #3;
    check("R11", {38'd0, out_valid, got_word()}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);

    // Table walk, one vector per clock (R2)
    for (int i = 0; i < NVEC + 4; i++) begin
      if (i >= 4) begin
        check($sformatf("R%0d vec%0d", VREQ[i-4], i-4), {27'd0, out_valid, got_word()},
              {27'd0, 1'b1, VEC[i-4][35:0]});
      end
      if (i < NVEC) drive(VEC[i], 1'b1);
      else          drive('0, 1'b0);
      @(negedge clk);
    end
    check("R2", {63'd0, out_valid}, 64'd0);

    // R12: a bubble between two operations
    drive(VEC[0], 1'b1); @(negedge clk);
    drive('0, 1'b0);     @(negedge clk);
    drive(VEC[1], 1'b1); @(negedge clk);
    drive('0, 1'b0);     @(negedge clk);
    check("R12 first", {27'd0, out_valid, got_word()}, {27'd0, 1'b1, VEC[0][35:0]});
    @(negedge clk);
    check("R12 bubble", {27'd0, out_valid, got_word()}, {27'd0, 1'b0, VEC[0][35:0]});
    @(negedge clk);
    check("R12 after", {27'd0, out_valid, got_word()}, {27'd0, 1'b1, VEC[1][35:0]});

    // R11: asynchronous reset with the pipe full
    for (int i = 0; i < 4; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
    end
    check("R11 full", {63'd0, out_valid}, 64'd1);
    #2 rst_n = 1'b0;
    #1 check("R11 async", {27'd0, out_valid, got_word()}, 64'd0);
    drive('0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 drained", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule